// File: doc/BRIEF.md
# Character LCD Command Sequencer (host side, 8-bit bus)

This block drives a character LCD controller over an 8-bit parallel bus with a register-select line, a read/write line and an enable strobe. Commands come in on a valid/ready port. Each command is a register-select bit and a byte. Before every write, the sequencer reads the controller status until the busy bit reads clear. It then waits a short guard interval and performs the write, with setup, pulse and hold times counted in host clock cycles.

After reset the sequencer can first send a fixed power-on list of four instructions. These are Function Set for 8-bit mode, then display on/off control, then Clear, then Entry Mode. Only after the list has been sent does it accept requests.

The controller may never report ready. For that case a polling budget applies, chosen by the class of the previously written command. When the budget runs out, the sequencer performs the write anyway and sets a sticky error flag.

The FSM has eight states:

| State | Role |
|---|---|
| IDLE | Waiting for the next command |
| RD_SETUP, RD_PULSE, RD_HOLD | Status read |
| GUARD | Gap between a read that ends polling and the write |
| WR_SETUP, WR_PULSE, WR_HOLD | Command write |

The transitions are:
- IDLE→RD_SETUP, on a pending init entry or an accepted request.
- RD_SETUP→RD_PULSE→RD_HOLD, at the end of each phase.
- RD_HOLD→RD_SETUP, when the sample read busy and the budget is not spent.
- RD_HOLD→GUARD, when the sample read not busy, or on timeout.
- GUARD→WR_SETUP→WR_PULSE→WR_HOLD, at the end of each phase.
- WR_HOLD→IDLE, at the end of the hold phase.

Top module: `lcd_cmd_seq`

## Requirements
- R1: With INIT_ON=1, after reset the block writes, in this order, the instructions 0x30|N<<3|F<<2, 0x08|DISP, 0x01 and 0x04|ENTRY, each with lcd_rs=0. N is INIT_TWO_LINE, F is INIT_BIG_FONT, DISP is a 3-bit parameter and ENTRY is a 2-bit parameter. req_ready stays 0 until the fourth write ends.
- R2: req_ready is 1 exactly in IDLE with no init entry pending. A request is accepted at a rising clock edge where req_valid and req_ready are both 1.
- R3: Each command starts with a status read: lcd_rs=0, lcd_rw=1, lcd_db_oe=0, lcd_db_out=0. lcd_en is low for T_SETUP cycles, high for T_PULSE cycles, then low for T_HOLD cycles.
- R4: lcd_busy_in is sampled in the last cycle with lcd_en high. A 1 causes another status read, unless R7 applies.
- R5: After a status read that ends polling, T_GUARD cycles follow with the bus released and lcd_en low, before the write setup starts.
- R6: A write drives lcd_rs = the request's rs bit, lcd_rw=0, lcd_db_oe=1 and lcd_db_out = the byte. It uses T_SETUP low, T_PULSE high and T_HOLD low cycles of lcd_en, then returns to IDLE. In IDLE: lcd_rs=0, lcd_rw=1, lcd_en=0, lcd_db_oe=0, lcd_db_out=0.
- R7: The polling budget depends on the previous write. A data write (rs=1) gives TO_DATA. An instruction byte 0x01 to 0x03 gives TO_LONG. Any other instruction gives TO_SHORT. The budget after reset is TO_LONG. A busy status read times out when the number of clock edges since the command left IDLE, not counting the edge ending that read, is at least the budget. The block then proceeds to GUARD and the write.
- R8: timeout_err is 0 after reset, becomes 1 on the edge where a timeout occurs, and stays 1 until reset.
- R9: Every accepted command is written exactly once, in the order accepted.
- R10: While a command is in progress, req_ready is 0, and req_valid has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_rs | input | 1 | 1 = data byte, 0 = instruction |
| req_data | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| lcd_rs | output | 1 | Register select to the controller |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_en | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Bus value driven during writes |
| lcd_db_oe | output | 1 | Bus driver enable; 0 releases the bus |
| lcd_busy_in | input | 1 | Bus bit 7 as seen during a status read |
| timeout_err | output | 1 | Sticky busy-timeout flag |

## Verification
The assertions assume that req_valid, req_rs and req_data change only away from the rising clock edge. They also assume that lcd_busy_in is stable while lcd_en is high. The bench drives requests at falling edges. It holds req_valid until the request is accepted and drops it in the following cycle. Its controller model changes the busy bit only on a falling enable edge, reloading a busy-read count after each write. This keeps the sampled bit free of races. The timeout cases are reached by setting that count past the polling budget of both the long and the short class.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_PULSE,
        ST_RD_HOLD,
        ST_GUARD,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        WC_SHORT,
        WC_LONG,
        WC_DATA
    } wait_class_t;

    typedef struct packed {
        logic       rs;
        logic [7:0] code;
    } lcd_cmd_t;

    // Budget class a command leaves behind for the next poll.
    function automatic wait_class_t class_of(input lcd_cmd_t c);
        if (c.rs) begin
            return WC_DATA;
        end
        if (c.code[7:2] == 6'd0 && c.code[1:0] != 2'd0) begin
            return WC_LONG;
        end
        return WC_SHORT;
    endfunction

endpackage

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
    import lcd_seq_pkg::*;
#(
    parameter bit         TWO_LINE   = 1'b1,
    parameter bit         BIG_FONT   = 1'b0,
    parameter logic [2:0] DISP_BITS  = 3'b100,
    parameter logic [1:0] ENTRY_BITS = 2'b10
) (
    input  logic [1:0] idx,
    output lcd_cmd_t   cmd
);

    always_comb begin
        cmd.rs = 1'b0;
        unique case (idx)
            2'd0:    cmd.code = {4'b0011, TWO_LINE, BIG_FONT, 2'b00};
            2'd1:    cmd.code = {5'b00001, DISP_BITS};
            2'd2:    cmd.code = 8'h01;
            default: cmd.code = {6'b000001, ENTRY_BITS};
        endcase
    end

endmodule

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] span,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (!last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == span - 1'b1);

endmodule

// File: rtl/lcd_wait_meter.sv
module lcd_wait_meter
    import lcd_seq_pkg::*;
#(
    parameter int unsigned TO_SHORT = 2000,
    parameter int unsigned TO_LONG  = 80000,
    parameter int unsigned TO_DATA  = 2300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        run,
    input  logic        commit,
    input  wait_class_t commit_class,
    output logic        expired
);

    localparam int unsigned TO_MAX = (TO_LONG > TO_SHORT)
                                   ? ((TO_LONG > TO_DATA) ? TO_LONG : TO_DATA)
                                   : ((TO_SHORT > TO_DATA) ? TO_SHORT : TO_DATA);
    localparam int unsigned CW = $clog2(TO_MAX + 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    wait_class_t   cls;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            cls <= WC_LONG;
        end else begin
            if (clear) begin
                cnt <= '0;
            end else if (run && cnt != {CW{1'b1}}) begin
                cnt <= cnt + 1'b1;
            end
            if (commit) begin
                cls <= commit_class;
            end
        end
    end

    always_comb begin
        unique case (cls)
            WC_DATA: limit = CW'(TO_DATA);
            WC_LONG: limit = CW'(TO_LONG);
            default: limit = CW'(TO_SHORT);
        endcase
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned T_SETUP       = 2,
    parameter int unsigned T_PULSE       = 12,
    parameter int unsigned T_HOLD        = 2,
    parameter int unsigned T_GUARD       = 1,
    parameter int unsigned TO_SHORT      = 2000,
    parameter int unsigned TO_LONG       = 80000,
    parameter int unsigned TO_DATA       = 2300,
    parameter bit          INIT_ON       = 1'b1,
    parameter bit          INIT_TWO_LINE = 1'b1,
    parameter bit          INIT_BIG_FONT = 1'b0,
    parameter logic [2:0]  INIT_DISP     = 3'b100,
    parameter logic [1:0]  INIT_ENTRY    = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_rs,
    input  logic [7:0] req_data,
    output logic       req_ready,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic       lcd_busy_in,
    output logic       timeout_err
);

    localparam int unsigned PH_AB  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int unsigned PH_CD  = (T_HOLD > T_GUARD) ? T_HOLD : T_GUARD;
    localparam int unsigned PH_MAX = (PH_AB > PH_CD) ? PH_AB : PH_CD;
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam int unsigned N_INIT = 4;

    seq_state_t      state, state_n;
    lcd_cmd_t        cmd_q, init_cmd;
    logic [1:0]      init_idx;
    logic            init_pend, from_init;
    logic            busy_q;
    logic [PH_W-1:0] span;
    logic            ph_last, ph_restart;
    logic            expired;
    logic            leave_idle, write_done;

    lcd_init_rom #(
        .TWO_LINE  (INIT_TWO_LINE),
        .BIG_FONT  (INIT_BIG_FONT),
        .DISP_BITS (INIT_DISP),
        .ENTRY_BITS(INIT_ENTRY)
    ) u_rom (
        .idx(init_idx),
        .cmd(init_cmd)
    );

    always_comb begin
        unique case (state)
            ST_RD_SETUP, ST_WR_SETUP: span = PH_W'(T_SETUP);
            ST_RD_PULSE, ST_WR_PULSE: span = PH_W'(T_PULSE);
            ST_RD_HOLD,  ST_WR_HOLD:  span = PH_W'(T_HOLD);
            ST_GUARD:                 span = PH_W'(T_GUARD);
            default:                  span = PH_W'(1);
        endcase
    end

    assign ph_restart = (state_n != state);
    assign leave_idle = (state == ST_IDLE) && (state_n == ST_RD_SETUP);
    assign write_done = (state == ST_WR_HOLD) && ph_last;

    lcd_phase_timer #(.W(PH_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(ph_restart),
        .span   (span),
        .last   (ph_last)
    );

    lcd_wait_meter #(
        .TO_SHORT(TO_SHORT),
        .TO_LONG (TO_LONG),
        .TO_DATA (TO_DATA)
    ) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (leave_idle),
        .run         (state != ST_IDLE),
        .commit      (write_done),
        .commit_class(class_of(cmd_q)),
        .expired     (expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (init_pend || req_valid) state_n = ST_RD_SETUP;
            ST_RD_SETUP: if (ph_last) state_n = ST_RD_PULSE;
            ST_RD_PULSE: if (ph_last) state_n = ST_RD_HOLD;
            ST_RD_HOLD:  if (ph_last) state_n = (busy_q && !expired) ? ST_RD_SETUP : ST_GUARD;
            ST_GUARD:    if (ph_last) state_n = ST_WR_SETUP;
            ST_WR_SETUP: if (ph_last) state_n = ST_WR_PULSE;
            ST_WR_PULSE: if (ph_last) state_n = ST_WR_HOLD;
            ST_WR_HOLD:  if (ph_last) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // Command, busy sample, error and init progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            from_init <= 1'b0;
            busy_q    <= 1'b0;
            timeout_err <= 1'b0;
            init_pend <= INIT_ON;
            init_idx  <= '0;
        end else begin
            if (leave_idle) begin
                cmd_q     <= init_pend ? init_cmd : lcd_cmd_t'({req_rs, req_data});
                from_init <= init_pend;
            end
            if (state == ST_RD_PULSE && ph_last) begin
                busy_q <= lcd_busy_in;
            end
            if (state == ST_RD_HOLD && ph_last && busy_q && expired) begin
                timeout_err <= 1'b1;
            end
            if (write_done && from_init) begin
                init_idx <= init_idx + 1'b1;
                if (init_idx == 2'(N_INIT - 1)) begin
                    init_pend <= 1'b0;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        lcd_rs     = 1'b0;
        lcd_rw     = 1'b1;
        lcd_en     = 1'b0;
        lcd_db_out = 8'h00;
        lcd_db_oe  = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = !init_pend;
            ST_RD_SETUP, ST_RD_HOLD, ST_GUARD: ;
            ST_RD_PULSE: lcd_en = 1'b1;
            ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD: begin
                lcd_rs     = cmd_q.rs;
                lcd_rw     = 1'b0;
                lcd_db_out = cmd_q.code;
                lcd_db_oe  = 1'b1;
                lcd_en     = (state == ST_WR_PULSE);
            end
            default: ;
        endcase
    end

    AST_EN_RISE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_db_out)); // R3
    AST_EN_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en && $past(lcd_en) |-> $stable(lcd_rw) && $stable(lcd_db_out) && $stable(lcd_db_oe)); // R6
    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw); // R6
    AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_en && !lcd_db_oe); // R2
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err); // R8
    AST_INIT_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !init_pend |=> !init_pend); // R1
    AST_GUARD_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_db_oe) |-> $past(state) == ST_GUARD); // R5

endmodule

// File: tb/tb_lcd_cmd_seq.sv
module tb_lcd_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TS = 2, TP = 3, TH = 2, TG = 1;
    localparam int TOS = 20, TOL = 60, TOD = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_rs = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       req_ready, lcd_rs, lcd_rw, lcd_en, lcd_db_oe, timeout_err;
    logic [7:0] lcd_db_out;
    logic       lcd_busy_in;

    int checks = 0;
    int fails = 0;
    int busy_left = 2;
    int busy_after_write = 1;
    int reads_seen = 0;
    int writes_seen = 0;

    // expected values from the model
    logic       e_ready = 1'b0, e_rs = 1'b0, e_rw = 1'b1, e_en = 1'b0, e_oe = 1'b0, e_err = 1'b0;
    logic [7:0] e_db = 8'h00;
    bit         model_on = 1'b0;
    int         m_cnt = 0;
    int         m_lim = TOL;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_cmd_seq #(
        .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_GUARD(TG),
        .TO_SHORT(TOS), .TO_LONG(TOL), .TO_DATA(TOD),
        .INIT_ON(1'b1), .INIT_TWO_LINE(1'b1), .INIT_BIG_FONT(1'b0),
        .INIT_DISP(3'b110), .INIT_ENTRY(2'b10)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_rs(req_rs), .req_data(req_data), .req_ready(req_ready),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
        .lcd_busy_in(lcd_busy_in), .timeout_err(timeout_err)
    );

    // Controller model: busy for a number of status reads after each write
    assign lcd_busy_in = (busy_left > 0);
    always @(negedge lcd_en) begin
        if (rst_n) begin
            if (lcd_rw == 1'b0) begin
                busy_left = busy_after_write;
                writes_seen++;
            end else begin
                reads_seen++;
                if (busy_left > 0) busy_left--;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // R9: write order
    always @(negedge lcd_en) begin
        if (rst_n && lcd_rw == 1'b0) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected write", {lcd_rs, lcd_db_out}, 9'h1ff);
            end else begin
                chk("R9 write order", {lcd_rs, lcd_db_out}, exp_q.pop_front());
            end
        end
    end

    // Every-clock comparison
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R2 req_ready", req_ready, e_ready);
            chk("R3 lcd_en", lcd_en, e_en);
            chk("R6 lcd_rs", lcd_rs, e_rs);
            chk("R6 lcd_rw", lcd_rw, e_rw);
            chk("R6 lcd_db_oe", lcd_db_oe, e_oe);
            chk("R6 lcd_db_out", lcd_db_out, e_db);
            chk("R8 timeout_err", timeout_err, e_err);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        m_cnt++;
    endtask

    task automatic bus_idle();
        e_rs = 1'b0; e_rw = 1'b1; e_en = 1'b0; e_oe = 1'b0; e_db = 8'h00;
    endtask

    // R3 R4 R5 R6 R7 behaviour of one command, starting just after leaving IDLE
    task automatic run_cmd(input logic rs, input logic [7:0] b);
        bit bz;
        bit done;
        exp_q.push_back({rs, b});
        m_cnt = 0;
        e_ready = 1'b0;
        done = 1'b0;
        while (!done) begin
            bus_idle();
            repeat (TS) step();
            e_en = 1'b1;
            repeat (TP - 1) step();
            bz = lcd_busy_in;          // R4 sample in last enable-high cycle
            step();
            e_en = 1'b0;
            repeat (TH - 1) step();
            if (!bz) begin
                done = 1'b1;
                step();
            end else if (m_cnt >= m_lim) begin  // R7 budget spent
                done = 1'b1;
                step();
                e_err = 1'b1;
            end else begin
                step();
            end
        end
        bus_idle();                    // R5 guard
        repeat (TG) step();
        e_rs = rs; e_rw = 1'b0; e_oe = 1'b1; e_db = b;
        repeat (TS) step();
        e_en = 1'b1;
        repeat (TP) step();
        e_en = 1'b0;
        repeat (TH) step();
        if (rs) m_lim = TOD;
        else if (b[7:2] == 6'd0 && b[1:0] != 2'd0) m_lim = TOL;
        else m_lim = TOS;
    endtask

    function automatic logic [7:0] init_byte(input int i);
        case (i)
            0: return 8'h38;
            1: return 8'h0E;
            2: return 8'h01;
            default: return 8'h06;
        endcase
    endfunction

    // Reference model
    initial begin
        int idx;
        logic r;
        logic [7:0] b;
        idx = 0;
        wait (rst_n === 1'b1);
        model_on = 1'b1;
        forever begin
            bus_idle();
            if (idx < 4) begin          // R1
                e_ready = 1'b0;
                step();
                run_cmd(1'b0, init_byte(idx));
                idx++;
            end else begin              // R2 R10
                e_ready = 1'b1;
                @(posedge clk);
                if (req_valid) begin
                    r = req_rs;
                    b = req_data;
                    #1;
                    run_cmd(r, b);
                end else begin
                    #1;
                end
            end
        end
    end

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic send(input logic rs, input logic [7:0] b);
        @(negedge clk);
        req_valid = 1'b1;
        req_rs = rs;
        req_data = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_rs = 1'b0;
        req_data = 8'h00;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 error low in reset", timeout_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready low while init pending", req_ready, 0);
        wait_idle();
        chk("R1 four init writes", writes_seen, 4);
        chk("R9 init queue drained", exp_q.size(), 0);

        reads_seen = 0;
        send(1'b1, 8'h48);
        wait_idle();
        chk("R4 one busy read then clear", reads_seen, 2);

        reads_seen = 0;
        send(1'b0, 8'h85);
        wait_idle();
        chk("R4 reads after data write", reads_seen, 2);
        chk("R7 no timeout yet", timeout_err, 0);

        busy_after_write = 40;
        send(1'b0, 8'h01);
        wait_idle();
        busy_after_write = 1;
        reads_seen = 0;
        send(1'b1, 8'h41);
        wait_idle();
        chk("R7 long budget read count", reads_seen, 9);
        chk("R8 error set on timeout", timeout_err, 1);

        busy_after_write = 40;
        send(1'b0, 8'h0C);
        wait_idle();
        busy_after_write = 1;
        reads_seen = 0;
        send(1'b0, 8'h14);
        wait_idle();
        chk("R7 short budget read count", reads_seen, 3);
        chk("R8 error stays set", timeout_err, 1);

        send(1'b1, 8'h5A);
        send(1'b1, 8'h5B);
        wait_idle();
        repeat (5) @(negedge clk);
        chk("R9 all writes done", exp_q.size(), 0);
        chk("R9 total writes", writes_seen, 12);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule